// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a reference clock into the 16x oversampling strobe that a UART transmitter and receiver share. The divide ratio is a fixed-point number: an integer part plus a 6-bit fraction in units of 1/64. The divisor equals reference clock × 64 / (16 × baud). A host that holds the rate in 1/16-baud units rounds to nearest by adding half the rate to the numerator before dividing, then splits the result into its low 6 bits (fraction) and upper bits (integer). Each strobe period lasts either the integer count or one cycle more. A 6-bit accumulator chooses which, so that over 64 strobes the total length is exactly 64 × integer + fraction cycles.

A simple write port loads the integer divisor, the fractional divisor, the line control word and the enable bit. Divisor writes go into staging registers. They reach the live divisor only when the line control word is written, and they do so even when the written value is unchanged. Divisor and line-control writes are refused while the enable bit is set or while the transmitter reports it is still shifting a character out, stop bits included. The block passes that shifting indication on as its busy output.

Top module: `fbg_baud_gen`

## Requirements
- R1: After reset the enable bit is 0, the live integer and fractional divisors are 0, the live line control word is 0 and no strobe is produced.
- R2: A write with select 0 (integer, data bits 15:0) or select 1 (fraction, data bits 5:0) changes no output. A write with select 2 (line control, data bits 7:0) loads the line control word and copies both staged divisors into the live divisor on the same edge, even if the line control value is unchanged.
- R3: Writes with selects 0, 1 and 2 are ignored while the enable bit is 1 or while the busy input is 1.
- R4: A write with select 3 sets the enable bit from data bit 0 in all states. The busy output follows the transmitter-busy input in the same cycle.
- R5: The strobe is one clock wide and is never produced while the enable bit is 0 or the live integer divisor is 0.
- R6: With enable set and a live integer divisor N, the first strobe comes in the N-th cycle after the enable bit becomes 1.
- R7: Every strobe period is N or N+1 cycles. At each strobe the fraction is added to a 6-bit accumulator, and the period that follows is N+1 exactly when that addition carries out of 6 bits.
- R8: Any 64 consecutive strobe periods sum to 64 × N + fraction cycles.
- R9: Clearing the enable bit clears the period counter and the accumulator, so a later enable restarts as described in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 integer, 1 fraction, 2 line control, 3 enable |
| wr_data | input | 16 | Write data |
| tx_busy_i | input | 1 | Transmitter still shifting a character |
| tick_o | output | 1 | 16x oversampling strobe |
| busy_o | output | 1 | Busy indication to the host |
| enable_o | output | 1 | Live enable bit |
| div_int_o | output | 16 | Live integer divisor |
| div_frac_o | output | 6 | Live fractional divisor |
| line_ctrl_o | output | 8 | Live line control word |

## Verification
The bench builds the block with its default widths: a 16-bit integer divisor, a 6-bit fraction and an 8-bit line control word. Small integer divisors (1, 3, 5) keep each strobe period a few cycles long, so full 64-strobe windows fit in a short run. Fractions of 0, 21 and 32 produce no carry, an irregular carry pattern and strict alternation of N and N+1. A divisor of 0 and repeated enable and disable sequences cover the idle and restart cases.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    localparam int DIV_INT_W  = 16;
    localparam int DIV_FRAC_W = 6;
    localparam int LINE_W     = 8;
    localparam int WDATA_W    = 16;
    localparam int SEL_W      = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_INT  = 2'd0,
        SEL_FRAC = 2'd1,
        SEL_LINE = 2'd2,
        SEL_CTRL = 2'd3
    } fbg_sel_e;

    typedef struct packed {
        logic [DIV_INT_W-1:0]  ip;
        logic [DIV_FRAC_W-1:0] fp;
    } fbg_div_t;

    // Value the period counter holds in the last cycle of a period.
    function automatic logic [DIV_INT_W:0] fbg_last_count(
        input logic [DIV_INT_W-1:0] ip,
        input logic                 ext
    );
        return {1'b0, ip} - {{DIV_INT_W{1'b0}}, 1'b1} + {{DIV_INT_W{1'b0}}, ext};
    endfunction

endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
    import fbg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  fbg_sel_e            wr_sel,
    input  logic [WDATA_W-1:0]  wr_data,
    input  logic                busy,
    output fbg_div_t            active,
    output logic [LINE_W-1:0]   line_ctrl,
    output logic                enable
);

    fbg_div_t staged;
    logic     locked;

    assign locked = enable | busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged    <= '0;
            active    <= '0;
            line_ctrl <= '0;
            enable    <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_CTRL: enable <= wr_data[0];
                SEL_INT:  if (!locked) staged.ip <= wr_data[DIV_INT_W-1:0];
                SEL_FRAC: if (!locked) staged.fp <= wr_data[DIV_FRAC_W-1:0];
                SEL_LINE: if (!locked) begin
                    line_ctrl <= wr_data[LINE_W-1:0];
                    active    <= staged;
                end
                default: ;
            endcase
        end
    end

    // R2: the live divisor moves only on a line control write
    a_r2_hold_until_line: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == SEL_LINE) |=> $stable(active));

    // R3: locked writes leave live state untouched
    a_r3_locked_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel != SEL_CTRL && locked) |=> ($stable(active) && $stable(line_ctrl)));

endmodule

// File: rtl/fbg_frac_acc.sv
module fbg_frac_acc
    import fbg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  tick,
    input  logic [DIV_FRAC_W-1:0] frac,
    output logic [DIV_FRAC_W-1:0] acc,
    output logic                  extend
);

    logic [DIV_FRAC_W:0] sum;

    assign sum = {1'b0, acc} + {1'b0, frac};

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc    <= '0;
            extend <= 1'b0;
        end else if (tick) begin
            acc    <= sum[DIV_FRAC_W-1:0];
            extend <= sum[DIV_FRAC_W];
        end
    end

    // R7: an extended period only starts at a strobe
    a_r7_extend_at_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(extend) |-> $past(tick));

endmodule

// File: rtl/fbg_period_cnt.sv
module fbg_period_cnt
    import fbg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic [DIV_INT_W-1:0] div_int,
    input  logic                 extend,
    output logic [DIV_INT_W-1:0] cnt,
    output logic                 tick
);

    assign tick = run && ({1'b0, cnt} == fbg_last_count(div_int, extend));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: the count never passes the longest period
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= div_int));

    // R5: strobe is a single cycle when periods exceed one clock
    a_r5_one_wide: assert property (@(posedge clk) disable iff (rst)
        (tick && div_int >= 2) |=> !tick);

endmodule

// File: rtl/fbg_baud_gen.sv
module fbg_baud_gen
    import fbg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [WDATA_W-1:0]    wr_data,
    input  logic                  tx_busy_i,
    output logic                  tick_o,
    output logic                  busy_o,
    output logic                  enable_o,
    output logic [DIV_INT_W-1:0]  div_int_o,
    output logic [DIV_FRAC_W-1:0] div_frac_o,
    output logic [LINE_W-1:0]     line_ctrl_o
);

    fbg_div_t              live;
    logic                  run;
    logic                  extend;
    logic                  tick;
    logic [DIV_FRAC_W-1:0] acc;
    logic [DIV_INT_W-1:0]  cnt;

    fbg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (fbg_sel_e'(wr_sel)),
        .wr_data   (wr_data),
        .busy      (tx_busy_i),
        .active    (live),
        .line_ctrl (line_ctrl_o),
        .enable    (enable_o)
    );

    assign run = enable_o && (live.ip != '0);

    fbg_period_cnt u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_int (live.ip),
        .extend  (extend),
        .cnt     (cnt),
        .tick    (tick)
    );

    fbg_frac_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (tick),
        .frac   (live.fp),
        .acc    (acc),
        .extend (extend)
    );

    assign tick_o     = tick;
    assign busy_o     = tx_busy_i;
    assign div_int_o  = live.ip;
    assign div_frac_o = live.fp;

    // R9: a stopped generator has cleared its counter and accumulator
    a_r9_cleared_when_idle: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!run -> (cnt == '0 && acc == '0 && !extend)));

    // R3: live divisor is frozen while enabled
    a_r3_frozen_enabled: assert property (@(posedge clk) disable iff (rst)
        (enable_o && $past(enable_o)) |-> ($stable(div_int_o) && $stable(div_frac_o)));

endmodule

// File: tb/fbg_baud_gen_test.sv
module fbg_baud_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        tx_busy_i = 1'b0;
    logic        tick_o, busy_o, enable_o;
    logic [15:0] div_int_o;
    logic [5:0]  div_frac_o;
    logic [7:0]  line_ctrl_o;

    int n_chk = 0;
    int n_bad = 0;
    bit chk_on = 0;
    bit done = 0;

    // behavioural reference state
    int m_en, m_int, m_frac, m_sh_int, m_sh_frac, m_lcr, m_cnt, m_acc, m_ext;

    always #10 clk = ~clk;

    fbg_baud_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tx_busy_i(tx_busy_i), .tick_o(tick_o), .busy_o(busy_o), .enable_o(enable_o),
        .div_int_o(div_int_o), .div_frac_o(div_frac_o), .line_ctrl_o(line_ctrl_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int m_tick();
        if (m_en == 0 || m_int == 0) return 0;
        return (m_cnt == m_int - 1 + m_ext) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_int = 0; m_frac = 0; m_sh_int = 0; m_sh_frac = 0;
            m_lcr = 0; m_cnt = 0; m_acc = 0; m_ext = 0;
        end else begin
            int lock;
            lock = (m_en != 0 || tx_busy_i) ? 1 : 0;
            if (m_en == 0 || m_int == 0) begin
                m_cnt = 0; m_acc = 0; m_ext = 0;
            end else if (m_tick() != 0) begin
                m_cnt = 0;
                m_ext = (m_acc + m_frac) / 64;
                m_acc = (m_acc + m_frac) % 64;
            end else begin
                m_cnt++;
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd3: m_en = int'(wr_data[0]);
                    2'd0: if (lock == 0) m_sh_int = int'(wr_data);
                    2'd1: if (lock == 0) m_sh_frac = int'(wr_data[5:0]);
                    default: if (lock == 0) begin
                        m_lcr = int'(wr_data[7:0]); m_int = m_sh_int; m_frac = m_sh_frac;
                    end
                endcase
            end
        end
    end

    always begin
        @(negedge clk);
        #2;
        if (chk_on && !done) begin
            chk("R6/R7 model tick_o", int'(tick_o), m_tick());
            chk("R2 model div_int_o", int'(div_int_o), m_int);
            chk("R2 model div_frac_o", int'(div_frac_o), m_frac);
            chk("R2 model line_ctrl_o", int'(line_ctrl_o), m_lcr);
            chk("R4 model enable_o", int'(enable_o), m_en);
            chk("R4 model busy_o", int'(busy_o), int'(tx_busy_i));
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // from just after a strobe sample, count cycles to the next strobe
    task automatic next_tick(output int n);
        n = 0;
        do begin
            @(negedge clk); #2; n++;
        end while (!tick_o && n < 1000);
    endtask

    task automatic first_tick(output int n);
        n = 1;
        #2;
        while (!tick_o && n < 1000) begin
            @(negedge clk); #2; n++;
        end
    endtask

    task automatic window(input int ni, input int nf, input string tag);
        int p, sum, acc, carry;
        first_tick(p);
        chk({tag, " R6 first strobe delay"}, p, ni);
        sum = 0; acc = 0; carry = 0;
        for (int k = 0; k < 64; k++) begin
            carry = (acc + nf) / 64;
            acc = (acc + nf) % 64;
            next_tick(p);
            sum += p;
            if (p != ni + carry) chk({tag, " R7 period"}, p, ni + carry);
        end
        chk({tag, " R8 64-period sum"}, sum, 64 * ni + nf);
    endtask

    initial begin
        int p, seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_on = 1;
        #2;
        chk("R1 enable after reset", int'(enable_o), 0);
        chk("R1 div_int after reset", int'(div_int_o), 0);
        chk("R1 line_ctrl after reset", int'(line_ctrl_o), 0);
        chk("R1 tick after reset", int'(tick_o), 0);

        wr(2'd0, 16'd5);
        wr(2'd1, 16'd0);
        #2 chk("R2 staged int not live", int'(div_int_o), 0);
        wr(2'd2, 16'h0070);
        #2 chk("R2 int live after line write", int'(div_int_o), 5);
        chk("R2 line word", int'(line_ctrl_o), 8'h70);

        wr(2'd3, 16'd1);
        window(5, 0, "N5F0");

        wr(2'd0, 16'd7);
        wr(2'd2, 16'h0011);
        wr(2'd3, 16'd0);
        #2 chk("R3 int write while enabled ignored", int'(div_int_o), 5);
        chk("R3 line write while enabled ignored", int'(line_ctrl_o), 8'h70);

        tx_busy_i = 1'b1;
        wr(2'd0, 16'd9);
        wr(2'd2, 16'h0022);
        #2 chk("R4 busy_o follows input", int'(busy_o), 1);
        chk("R3 write while busy ignored", int'(div_int_o), 5);
        chk("R3 line while busy ignored", int'(line_ctrl_o), 8'h70);
        tx_busy_i = 1'b0;
        wr(2'd2, 16'h0070);
        #2 chk("R3 staged int untouched by busy write", int'(div_int_o), 5);

        wr(2'd0, 16'd3);
        wr(2'd1, 16'd21);
        wr(2'd2, 16'h0070);
        #2 chk("R2 same line value still copies int", int'(div_int_o), 3);
        chk("R2 same line value still copies frac", int'(div_frac_o), 21);
        wr(2'd3, 16'd1);
        window(3, 21, "N3F21");

        wr(2'd3, 16'd0);
        wr(2'd3, 16'd1);
        first_tick(p);
        chk("R9 restart first strobe delay", p, 3);
        next_tick(p);
        chk("R9 restart accumulator cleared", p, 3);

        wr(2'd3, 16'd0);
        wr(2'd0, 16'd0);
        wr(2'd2, 16'h0070);
        wr(2'd3, 16'd1);
        seen = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk); #2;
            if (tick_o) seen++;
        end
        chk("R5 zero divisor gives no strobe", seen, 0);

        wr(2'd3, 16'd0);
        wr(2'd0, 16'd1);
        wr(2'd1, 16'd32);
        wr(2'd2, 16'h0070);
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #2;
            if (tick_o) seen++;
        end
        chk("R5 no strobe while disabled", seen, 0);
        wr(2'd3, 16'd1);
        window(1, 32, "N1F32");

        wr(2'd3, 16'd0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule